// File: doc/BRIEF.md
# DMA Descriptor Host Error Checker

This block watches buffer descriptors as a DMA engine fetches them and decides whether each one breaks the host rules for its direction. The engine presents one descriptor's fields for a single cycle with a valid strobe. A direction flag selects the transmit or receive rule set. Transmit checking follows packets across descriptors: it keeps track of whether a packet is open and how many bytes its buffers have added up to so far.

The first violation sets a sticky error flag. That flag stores a 4-bit code and the direction of the faulting descriptor, and later violations cannot change it. Only reset clears the error state. A write-one enable-set and enable-clear pair gates the flag onto a level interrupt. The raw flag, the gated interrupt and the enable state are all visible at the ports, which helps with debug of descriptor-building software.

Top module: `dma_desc_err_chk`

## Requirements
- R1: After reset, err_raw, err_irq, irq_en and err_dir are 0 and err_code is 0 (no error).
- R2: On transmit, code 1 is raised in two cases: a descriptor that starts a packet lacks the start flag, or a start flag arrives while a packet is still open (an open packet is one that has had a start and no end yet).
- R3: On transmit, a descriptor with the start flag and the owner bit clear raises code 2.
- R4: On transmit, a descriptor without the end flag whose next pointer is zero raises code 3.
- R5: On transmit, a zero buffer pointer raises code 4 and a zero buffer length raises code 5.
- R6: On transmit, at the end-flag descriptor, code 6 is raised if the buffer lengths summed from start to end differ from the packet length given in the start descriptor. This also applies to a single descriptor carrying both flags.
- R7: On receive, a clear owner bit raises code 8 and a zero buffer pointer raises code 9.
- R8: On receive, a zero buffer length on a descriptor without the start flag raises code 10. A start descriptor whose buffer length is not greater than its buffer offset raises code 11, so equal values fail and a larger length passes.
- R9: When one descriptor breaks several rules, the lowest code among them is recorded.
- R10: Only the first error is stored. Later errors leave err_code and err_dir unchanged. err_dir is 1 for a receive error and 0 for a transmit error.
- R11: Once set, err_raw, err_code and err_dir stay unchanged until reset. Enable writes do not clear them.
- R12: A pulse on mask_set sets irq_en and a pulse on mask_clr clears it. mask_clr wins when both are pulsed together. err_irq equals err_raw AND irq_en.
- R13: The error flag is set on the clock edge after the cycle in which desc_valid is high with an offending descriptor. Descriptor fields presented without desc_valid have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | Descriptor fields are valid this cycle |
| desc_dir_rx | input | 1 | 1 = receive descriptor, 0 = transmit descriptor |
| desc_own | input | 1 | Owner bit (set = the DMA engine owns the buffer) |
| desc_sop | input | 1 | Start-of-packet flag |
| desc_eop | input | 1 | End-of-packet flag |
| desc_next_ptr | input | AW | Next descriptor pointer |
| desc_buf_ptr | input | AW | Buffer pointer |
| desc_buf_len | input | LW | Buffer length |
| desc_buf_off | input | LW | Buffer offset (receive start descriptor) |
| desc_pkt_len | input | LW | Packet length (transmit start descriptor) |
| mask_set | input | 1 | Write-one pulse that enables the interrupt |
| mask_clr | input | 1 | Write-one pulse that disables the interrupt |
| err_raw | output | 1 | Sticky raw error flag |
| err_irq | output | 1 | Gated error interrupt level |
| irq_en | output | 1 | Current interrupt enable |
| err_code | output | 4 | Code of the first error |
| err_dir | output | 1 | Direction of the first error |

## Verification
The packet-length mismatch is the hardest case to reach, because it only appears after a run of descriptors that are each legal on their own. The stimulus therefore sends a correct start descriptor carrying the packet length, then an end descriptor whose buffer length makes the total one short of or beyond that length. It also sends a matching two-descriptor packet that must raise nothing. Rule priority and first-error retention are reached by loading one descriptor with several faults at once, and by following a transmit fault with a receive fault.

// File: rtl/dma_err_pkg.sv
// Package: shared error codes for the descriptor host error checker.
// Assumes codes are 4 bits wide; 0 means no error, and lower codes win.
package dma_err_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        E_NONE         = 4'd0,
        E_TX_SOP       = 4'd1,
        E_TX_OWN       = 4'd2,
        E_TX_NEXT_ZERO = 4'd3,
        E_TX_PTR_ZERO  = 4'd4,
        E_TX_LEN_ZERO  = 4'd5,
        E_TX_PKT_LEN   = 4'd6,
        E_RX_OWN       = 4'd8,
        E_RX_PTR_ZERO  = 4'd9,
        E_RX_LEN_MID   = 4'd10,
        E_RX_OFFSET    = 4'd11
    } err_code_e;
endpackage

// File: rtl/dma_tx_rules.sv
// Transmit rule set: checks one descriptor per valid cycle and tracks the
// open packet (open flag, running length sum, expected length).
// Assumes the caller gates desc_fire to transmit descriptors only.
module dma_tx_rules
    import dma_err_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_fire,
    input  logic          own,
    input  logic          sop,
    input  logic          eop,
    input  logic [AW-1:0] next_ptr,
    input  logic [AW-1:0] buf_ptr,
    input  logic [LW-1:0] buf_len,
    input  logic [LW-1:0] pkt_len,
    output err_code_e     code
);
    localparam int ACC_W = LW + 8;

    logic             in_pkt;
    logic [ACC_W-1:0] acc_len;
    logic [LW-1:0]    exp_len;
    logic [ACC_W-1:0] sum_len;
    logic [LW-1:0]    want_len;

    // Running total including this descriptor; a start flag restarts it.
    always_comb begin
        sum_len  = (sop ? '0 : acc_len) + ACC_W'(buf_len);
        want_len = sop ? pkt_len : exp_len;
    end

    // Rule evaluation, lowest code first.
    always_comb begin
        code = E_NONE;
        if (sop == in_pkt)
            code = E_TX_SOP;
        else if (sop && !own)
            code = E_TX_OWN;
        else if (!eop && next_ptr == '0)
            code = E_TX_NEXT_ZERO;
        else if (buf_ptr == '0)
            code = E_TX_PTR_ZERO;
        else if (buf_len == '0)
            code = E_TX_LEN_ZERO;
        else if (eop && sum_len != ACC_W'(want_len))
            code = E_TX_PKT_LEN;
    end

    // Packet tracking state, advanced on each transmit descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt  <= 1'b0;
            acc_len <= '0;
            exp_len <= '0;
        end else if (desc_fire) begin
            in_pkt  <= !eop;
            acc_len <= eop ? '0 : sum_len;
            if (sop)
                exp_len <= pkt_len;
        end
    end
endmodule

// File: rtl/dma_rx_rules.sv
// Receive rule set: purely combinational check of one descriptor.
// Assumes the caller only uses the code while a receive descriptor is valid.
module dma_rx_rules
    import dma_err_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          own,
    input  logic          sop,
    input  logic [AW-1:0] buf_ptr,
    input  logic [LW-1:0] buf_len,
    input  logic [LW-1:0] buf_off,
    output err_code_e     code
);
    // Rule evaluation, lowest code first.
    always_comb begin
        code = E_NONE;
        if (!own)
            code = E_RX_OWN;
        else if (buf_ptr == '0)
            code = E_RX_PTR_ZERO;
        else if (!sop && buf_len == '0)
            code = E_RX_LEN_MID;
        else if (sop && buf_len <= buf_off)
            code = E_RX_OFFSET;
    end
endmodule

// File: rtl/dma_err_latch.sv
// Sticky first-error store plus interrupt enable register.
// Assumes only reset may clear the stored error; clear beats set on the enable.
module dma_err_latch
    import dma_err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  err_code_e         code_in,
    input  logic              dir_in,
    input  logic              mask_set,
    input  logic              mask_clr,
    output logic              err_raw,
    output logic [CODE_W-1:0] err_code,
    output logic              err_dir,
    output logic              irq_en
);
    // Capture the first non-zero code only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_raw  <= 1'b0;
            err_code <= '0;
            err_dir  <= 1'b0;
        end else if (fire && code_in != E_NONE && !err_raw) begin
            err_raw  <= 1'b1;
            err_code <= code_in;
            err_dir  <= dir_in;
        end
    end

    // Write-one enable set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en <= 1'b0;
        else if (mask_clr)
            irq_en <= 1'b0;
        else if (mask_set)
            irq_en <= 1'b1;
    end
endmodule

// File: rtl/dma_desc_err_chk.sv
// Top: routes each valid descriptor to the rule set for its direction and
// latches the first violation. Assumes one descriptor per valid cycle.
module dma_desc_err_chk
    import dma_err_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_valid,
    input  logic          desc_dir_rx,
    input  logic          desc_own,
    input  logic          desc_sop,
    input  logic          desc_eop,
    input  logic [AW-1:0] desc_next_ptr,
    input  logic [AW-1:0] desc_buf_ptr,
    input  logic [LW-1:0] desc_buf_len,
    input  logic [LW-1:0] desc_buf_off,
    input  logic [LW-1:0] desc_pkt_len,
    input  logic          mask_set,
    input  logic          mask_clr,
    output logic          err_raw,
    output logic          err_irq,
    output logic          irq_en,
    output logic [3:0]    err_code,
    output logic          err_dir
);
    err_code_e tx_code, rx_code, sel_code;
    logic      tx_fire;

    // Transmit state only advances on transmit descriptors.
    assign tx_fire  = desc_valid && !desc_dir_rx;
    assign sel_code = desc_dir_rx ? rx_code : tx_code;

    dma_tx_rules #(.AW(AW), .LW(LW)) tx_i (
        .clk(clk), .rst_n(rst_n), .desc_fire(tx_fire),
        .own(desc_own), .sop(desc_sop), .eop(desc_eop),
        .next_ptr(desc_next_ptr), .buf_ptr(desc_buf_ptr),
        .buf_len(desc_buf_len), .pkt_len(desc_pkt_len), .code(tx_code)
    );

    dma_rx_rules #(.AW(AW), .LW(LW)) rx_i (
        .own(desc_own), .sop(desc_sop), .buf_ptr(desc_buf_ptr),
        .buf_len(desc_buf_len), .buf_off(desc_buf_off), .code(rx_code)
    );

    dma_err_latch latch_i (
        .clk(clk), .rst_n(rst_n), .fire(desc_valid), .code_in(sel_code),
        .dir_in(desc_dir_rx), .mask_set(mask_set), .mask_clr(mask_clr),
        .err_raw(err_raw), .err_code(err_code), .err_dir(err_dir),
        .irq_en(irq_en)
    );

    // Gated interrupt level.
    assign err_irq = err_raw && irq_en;
endmodule

// File: rtl/dma_desc_err_chk_sva.sv
// Checker: temporal properties of the descriptor error checker, bound to the top.
// Assumes synchronous active-low reset.
module dma_desc_err_chk_sva #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          desc_valid,
    input logic          desc_dir_rx,
    input logic [AW-1:0] desc_buf_ptr,
    input logic          mask_set,
    input logic          mask_clr,
    input logic          err_raw,
    input logic          err_irq,
    input logic          irq_en,
    input logic [3:0]    err_code,
    input logic          err_dir
);
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_raw |=> err_raw && $stable(err_code) && $stable(err_dir));

    p_no_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!desc_valid && !err_raw) |=> !err_raw);

    p_tx_ptr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_dir_rx && desc_buf_ptr == '0 && !err_raw)
        |=> err_raw && !err_dir);

    p_rx_ptr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_dir_rx && desc_buf_ptr == '0 && !err_raw)
        |=> err_raw && err_dir);

    p_clr_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mask_clr |=> !irq_en && !err_irq);

    p_set_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_set && !mask_clr && err_raw) |=> err_irq);

    p_no_raw_no_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !err_raw |-> !err_irq);
endmodule

bind dma_desc_err_chk dma_desc_err_chk_sva #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid),
    .desc_dir_rx(desc_dir_rx), .desc_buf_ptr(desc_buf_ptr),
    .mask_set(mask_set), .mask_clr(mask_clr), .err_raw(err_raw),
    .err_irq(err_irq), .irq_en(irq_en), .err_code(err_code),
    .err_dir(err_dir)
);

// File: tb/dma_desc_err_chk_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module dma_desc_err_chk_tb_top;
    localparam int AW = 32;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_valid = 1'b0;
    logic          desc_dir_rx = 1'b0;
    logic          desc_own = 1'b0;
    logic          desc_sop = 1'b0;
    logic          desc_eop = 1'b0;
    logic [AW-1:0] desc_next_ptr = '0;
    logic [AW-1:0] desc_buf_ptr = '0;
    logic [LW-1:0] desc_buf_len = '0;
    logic [LW-1:0] desc_buf_off = '0;
    logic [LW-1:0] desc_pkt_len = '0;
    logic          mask_set = 1'b0;
    logic          mask_clr = 1'b0;
    logic          err_raw, err_irq, irq_en, err_dir;
    logic [3:0]    err_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_desc_err_chk #(.AW(AW), .LW(LW)) dut_i (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        desc_valid = 1'b0;
        mask_set = 1'b0;
        mask_clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one descriptor for one cycle; on return, the result is visible.
    task automatic send(input bit rx, input bit own, input bit sop, input bit eop,
                        input logic [AW-1:0] nxt, input logic [AW-1:0] ptr,
                        input int len, input int off, input int plen);
        @(negedge clk);
        desc_dir_rx = rx; desc_own = own; desc_sop = sop; desc_eop = eop;
        desc_next_ptr = nxt; desc_buf_ptr = ptr;
        desc_buf_len = LW'(len); desc_buf_off = LW'(off); desc_pkt_len = LW'(plen);
        desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic pulse_mask(input bit s, input bit c);
        @(negedge clk);
        mask_set = s; mask_clr = c;
        @(negedge clk);
        mask_set = 1'b0; mask_clr = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 raw", err_raw, 0);
        check("R1 code", err_code, 0);
        check("R1 irq", err_irq, 0);
        check("R1 en", irq_en, 0);
        check("R1 dir", err_dir, 0);
    endtask

    task automatic t_good();
        do_reset();
        send(0, 1, 1, 0, 32'h2000, 32'h1000, 100, 0, 160);
        send(0, 1, 0, 1, 32'h0, 32'h1100, 60, 0, 0);
        send(1, 1, 1, 0, 32'h0, 32'h3000, 64, 8, 0);
        send(1, 1, 0, 0, 32'h0, 32'h3100, 64, 0, 0);
        check("R6 matching packet no error", err_raw, 0);
        check("R8 len above offset passes", err_code, 0);
    endtask

    task automatic t_tx_sop();
        do_reset();
        send(0, 1, 0, 1, 32'h0, 32'h1000, 10, 0, 10);
        check("R2 missing start", err_code, 1);
        do_reset();
        send(0, 1, 1, 0, 32'h2000, 32'h1000, 10, 0, 20);
        send(0, 1, 1, 1, 32'h0, 32'h1000, 10, 0, 10);
        check("R2 start inside packet", err_code, 1);
    endtask

    task automatic t_tx_simple();
        do_reset();
        send(0, 0, 1, 1, 32'h0, 32'h1000, 10, 0, 10);
        check("R3 owner clear", err_code, 2);
        do_reset();
        send(0, 1, 1, 0, 32'h0, 32'h1000, 10, 0, 20);
        check("R4 next zero", err_code, 3);
        do_reset();
        send(0, 1, 1, 1, 32'h0, 32'h0, 10, 0, 10);
        check("R5 ptr zero", err_code, 4);
        do_reset();
        send(0, 1, 1, 1, 32'h0, 32'h1000, 0, 0, 0);
        check("R5 len zero", err_code, 5);
    endtask

    task automatic t_tx_pktlen();
        do_reset();
        send(0, 1, 1, 0, 32'h2000, 32'h1000, 100, 0, 150);
        check("R6 no error before end", err_raw, 0);
        send(0, 1, 0, 1, 32'h0, 32'h1100, 60, 0, 0);
        check("R6 sum mismatch", err_code, 6);
        do_reset();
        send(0, 1, 1, 1, 32'h0, 32'h1000, 40, 0, 41);
        check("R6 single descriptor mismatch", err_code, 6);
    endtask

    task automatic t_rx();
        do_reset();
        send(1, 0, 1, 0, 32'h0, 32'h3000, 64, 0, 0);
        check("R7 owner clear", err_code, 8);
        check("R10 dir rx", err_dir, 1);
        do_reset();
        send(1, 1, 0, 0, 32'h0, 32'h0, 64, 0, 0);
        check("R7 ptr zero", err_code, 9);
        do_reset();
        send(1, 1, 0, 0, 32'h0, 32'h3000, 0, 0, 0);
        check("R8 mid len zero", err_code, 10);
        do_reset();
        send(1, 1, 1, 0, 32'h0, 32'h3000, 16, 16, 0);
        check("R8 len equal offset", err_code, 11);
    endtask

    task automatic t_priority();
        do_reset();
        send(0, 1, 0, 0, 32'h0, 32'h0, 0, 0, 0);
        check("R9 tx lowest code", err_code, 1);
        do_reset();
        send(1, 0, 0, 0, 32'h0, 32'h0, 0, 0, 0);
        check("R9 rx lowest code", err_code, 8);
    endtask

    task automatic t_first();
        do_reset();
        send(0, 1, 1, 1, 32'h0, 32'h0, 10, 0, 10);
        send(1, 0, 1, 0, 32'h0, 32'h0, 0, 0, 0);
        check("R10 first code kept", err_code, 4);
        check("R10 first dir kept", err_dir, 0);
    endtask

    task automatic t_timing();
        do_reset();
        @(negedge clk);
        desc_dir_rx = 1'b0; desc_buf_ptr = '0; desc_own = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R13 fields without valid ignored", err_raw, 0);
        @(negedge clk);
        desc_valid = 1'b1;
        #1;
        check("R13 not set in strobe cycle", err_raw, 0);
        @(posedge clk);
        #1;
        desc_valid = 1'b0;
        check("R13 set after edge", err_raw, 1);
    endtask

    task automatic t_mask();
        do_reset();
        send(0, 1, 1, 1, 32'h0, 32'h0, 10, 0, 10);
        check("R12 masked irq low", err_irq, 0);
        pulse_mask(1, 0);
        check("R12 enable set", irq_en, 1);
        check("R12 irq high", err_irq, 1);
        pulse_mask(0, 1);
        check("R12 irq low after clear", err_irq, 0);
        check("R11 raw survives clear", err_raw, 1);
        check("R11 code survives clear", err_code, 4);
        pulse_mask(1, 0);
        pulse_mask(1, 1);
        check("R12 clear wins", irq_en, 0);
        repeat (5) @(negedge clk);
        check("R11 still sticky", err_raw, 1);
    endtask

    initial begin
        t_reset();
        t_good();
        t_tx_sop();
        t_tx_simple();
        t_tx_pktlen();
        t_rx();
        t_priority();
        t_first();
        t_timing();
        t_mask();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule